// File: doc/BRIEF.md
# Two-Digit Reaction Timer

This block measures how long a subject takes to respond, in hundredths of a second. An operator start pulse opens a run gate. While the gate is open, each 100 Hz tick enable advances a chain of decimal (BCD) digits. A stop pulse from the subject closes the gate and freezes a follow/hold output register, so the shown result stays put however often the subject presses again. With the default two digits, full scale is 0.99 s.

A clear input starts a new trial. It zeroes the digits, drops the run gate, releases the hold and clears the overflow flag. If the subject never responds and the count would pass its maximum, the counter stops at all nines and a sticky overflow flag is raised. The number of digits is a parameter. The counter is a generate-built cascade of decade stages in which each stage's wrap from 9 to 0 advances its neighbour.

Top module: `reaction_timer`

## Requirements
- R1: One cycle after `clr` is high (or after reset), `digits_bcd` is 0, `running` is 0 and `overflow` is 0.
- R2: A `start_pulse` while idle after a clear sets `running` in the next cycle. A tick in that same cycle is not counted.
- R3: Each tick seen while running adds one to the count. Digit i occupies bits [4i+3:4i] in BCD, with digit 0 the hundredths. Every digit counts 0 to 9, and a digit's wrap from 9 to 0 advances the next digit by one.
- R4: Ticks while not running leave the count and `digits_bcd` unchanged.
- R5: While not held, `digits_bcd` shows the live count with one cycle of lag.
- R6: A `stop_pulse` while running drops `running` in the next cycle and freezes `digits_bcd` at the count held in the stop cycle. A tick in the stop cycle is not counted.
- R7: Further stop pulses, and stop pulses while not running, change no output.
- R8: A start pulse while running is ignored. A start pulse after a stop or an overflow is also ignored until the next clear.
- R9: A tick while running at the all-nines count leaves the count at all nines, raises `overflow`, drops `running` and freezes the output. `overflow` then stays high until a clear, and `running` is never high together with it.
- R10: `clr` has priority over a start, stop or tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; begins a new trial |
| tick_100hz | input | 1 | One-cycle enable at 100 Hz |
| start_pulse | input | 1 | One-cycle start event from the operator |
| stop_pulse | input | 1 | One-cycle response event from the subject |
| digits_bcd | output | 4*NUM_DIGITS | Shown result, BCD, hundredths in the low digit |
| running | output | 1 | Gate open; ticks are being counted |
| overflow | output | 1 | Sticky; count reached full scale |

## Verification
The bench builds the block with the default NUM_DIGITS of 2. This keeps full scale at 99, so the overflow boundary is reached within one hundred ticks of a directed run. The random phase mixes clears, starts and stops with the cascade carry and saturation. Two digits are the fewest that still exercise a carry between decade stages. Coincident events in a single cycle are driven on purpose: stop with tick, start with tick, and clear with start.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
   localparam int unsigned RT_DIGIT_W = 4;
   localparam logic [RT_DIGIT_W-1:0] RT_DIGIT_MAX = 4'd9;
   typedef logic [RT_DIGIT_W-1:0] rt_digit_t;
   typedef struct packed {
      logic running;
      logic held;
      logic ovf;
   } rt_ctl_t;
endpackage

// File: rtl/rt_decade_digit.sv
`timescale 1ns/1ps
module rt_decade_digit
   import rt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      inc_in,
   output rt_digit_t value,
   output logic      at_max
);
   assign at_max = (value == RT_DIGIT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (inc_in)
         value <= at_max ? '0 : value + 1'b1;
   end
endmodule

// File: rtl/rt_decade_chain.sv
`timescale 1ns/1ps
module rt_decade_chain
   import rt_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             count_en,
   output logic [NUM_DIGITS*RT_DIGIT_W-1:0] count,
   output logic                             full
);
   logic [NUM_DIGITS-1:0] inc;
   logic [NUM_DIGITS-1:0] max_v;

   assign inc[0] = count_en;

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      rt_decade_digit i_digit (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .inc_in (inc[g]),
         .value  (count[g*RT_DIGIT_W +: RT_DIGIT_W]),
         .at_max (max_v[g])
      );
      if (g < NUM_DIGITS - 1) begin : g_carry
         assign inc[g+1] = inc[g] & max_v[g];
      end
   end

   assign full = &max_v;
endmodule

// File: rtl/rt_run_gate.sv
`timescale 1ns/1ps
module rt_run_gate
   import rt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clr,
   input  logic    start,
   input  logic    stop,
   input  logic    tick,
   input  logic    full,
   output rt_ctl_t ctl,
   output logic    count_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (clr) begin
         ctl <= '0;
      end else if (ctl.running) begin
         if (stop) begin
            ctl.running <= 1'b0;
            ctl.held    <= 1'b1;
         end else if (tick && full) begin
            ctl.running <= 1'b0;
            ctl.held    <= 1'b1;
            ctl.ovf     <= 1'b1;
         end
      end else if (!ctl.held && start) begin
         ctl.running <= 1'b1;
      end
   end

   assign count_en = ctl.running & tick & ~stop & ~full;
endmodule

// File: rtl/rt_hold_reg.sv
`timescale 1ns/1ps
module rt_hold_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (!hold)
         q <= d;
   end
endmodule

// File: rtl/reaction_timer.sv
`timescale 1ns/1ps
module reaction_timer
   import rt_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             tick_100hz,
   input  logic                             start_pulse,
   input  logic                             stop_pulse,
   output logic [NUM_DIGITS*RT_DIGIT_W-1:0] digits_bcd,
   output logic                             running,
   output logic                             overflow
);
   localparam int unsigned CNT_W = NUM_DIGITS * RT_DIGIT_W;

   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("reaction_timer: NUM_DIGITS must lie in 1..8");
   end

   logic [CNT_W-1:0] live_count;
   logic             full;
   logic             count_en;
   rt_ctl_t          ctl;

   rt_run_gate i_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .start    (start_pulse),
      .stop     (stop_pulse),
      .tick     (tick_100hz),
      .full     (full),
      .ctl      (ctl),
      .count_en (count_en)
   );

   rt_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) i_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .count_en (count_en),
      .count    (live_count),
      .full     (full)
   );

   rt_hold_reg #(.WIDTH(CNT_W)) i_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .hold  (ctl.held),
      .d     (live_count),
      .q     (digits_bcd)
   );

   assign running  = ctl.running;
   assign overflow = ctl.ovf;
endmodule

// File: rtl/reaction_timer_chk.sv
`timescale 1ns/1ps
module reaction_timer_chk #(
   parameter int unsigned NUM_DIGITS = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr,
   input logic                    tick_100hz,
   input logic                    start_pulse,
   input logic                    stop_pulse,
   input logic [NUM_DIGITS*4-1:0] digits_bcd,
   input logic                    running,
   input logic                    overflow
);
   // R1
   clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (digits_bcd == '0 && !running && !overflow));

   // R6
   stop_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && stop_pulse && !clr) |=> !running);

   // R7
   frozen_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !clr) |=> $stable(digits_bcd));

   // R8
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start_pulse && !stop_pulse && !tick_100hz && !clr) |=> running);

   // R9
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clr) |=> overflow);

   // R9
   overflow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !running);

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_range
      // R3
      digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         digits_bcd[g*4 +: 4] <= 4'd9);
   end
endmodule

bind reaction_timer reaction_timer_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (.*);

// File: tb/test_reaction_timer.sv
`timescale 1ns/1ps
module test_reaction_timer;
   localparam int ND   = 2;
   localparam int W    = ND * 4;
   localparam int MAXV = 10 ** ND - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr = 1'b0;
   logic         tick = 1'b0;
   logic         start = 1'b0;
   logic         stop = 1'b0;
   logic [W-1:0] digits;
   logic         running;
   logic         overflow;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   int m_cnt = 0;
   int m_shown = 0;
   bit m_run = 0;
   bit m_held = 0;
   bit m_ovf = 0;

   always #5 clk = ~clk;

   reaction_timer #(.NUM_DIGITS(ND)) i_reaction_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .tick_100hz  (tick),
      .start_pulse (start),
      .stop_pulse  (stop),
      .digits_bcd  (digits),
      .running     (running),
      .overflow    (overflow)
   );

   function automatic logic [W-1:0] to_bcd(input int v);
      logic [W-1:0] r = '0;
      for (int i = 0; i < ND; i++) begin
         r[i*4 +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk({tag, " digits"},  digits, to_bcd(m_shown));
      chk({tag, " running"}, W'(running), W'(m_run));
      chk({tag, " overflow"}, W'(overflow), W'(m_ovf));
   endtask

   // drive at negedge, model the edge, compare at next negedge
   task automatic step(input bit c, input bit s, input bit p, input bit t, input string tag);
      int nshown;
      clr = c; start = s; stop = p; tick = t;
      @(posedge clk);
      if (c) begin
         m_cnt = 0; m_shown = 0; m_run = 0; m_held = 0; m_ovf = 0;
      end else begin
         nshown = m_held ? m_shown : m_cnt;
         if (m_run) begin
            if (p) begin
               m_run = 0; m_held = 1;
            end else if (t) begin
               if (m_cnt == MAXV) begin
                  m_run = 0; m_held = 1; m_ovf = 1;
               end else begin
                  m_cnt++;
               end
            end
         end else if (!m_held && s) begin
            m_run = 1;
         end
         m_shown = nshown;
      end
      @(negedge clk);
      clr = 0; start = 0; stop = 0; tick = 0;
      compare(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240409));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset");

      // R4: ticks while idle do nothing
      repeat (5) step(0, 0, 0, 1, "R4 idle tick");

      // R2: start together with a tick; that tick is not counted
      step(0, 1, 0, 1, "R2 start");
      step(0, 0, 0, 0, "R2 running");
      chk("R2 first count", digits, 8'h00);

      // R3/R5: ten ticks carry into the tens digit
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, "R3 tick");
      step(0, 0, 0, 0, "R5 follow");
      chk("R3 carry 9->10", digits, 8'h10);

      // R8: start while running has no effect
      step(0, 1, 0, 0, "R8 start while running");
      step(0, 0, 0, 1, "R5 tick");
      step(0, 0, 0, 0, "R5 follow");
      chk("R5 live count", digits, 8'h11);

      // R6: stop coincident with tick; tick not counted
      step(0, 0, 1, 1, "R6 stop");
      chk("R6 frozen value", digits, 8'h11);
      chk("R6 running low", W'(running), W'(0));

      // R7: further stops and ticks change nothing
      step(0, 0, 1, 0, "R7 second stop");
      step(0, 0, 1, 1, "R7 third stop");
      repeat (4) step(0, 0, 0, 1, "R7 held tick");
      chk("R7 still frozen", digits, 8'h11);

      // R8: start after a stop is ignored until clear
      step(0, 1, 0, 0, "R8 start after stop");
      repeat (3) step(0, 0, 0, 1, "R8 ignored ticks");
      chk("R8 no restart", W'(running), W'(0));

      // R1 clear; R10 clear beats start
      step(1, 1, 0, 1, "R10 clear with start");
      chk("R10 not running", W'(running), W'(0));
      chk("R1 cleared digits", digits, 8'h00);

      // R7: stop while idle does nothing, then a normal start
      step(0, 0, 1, 0, "R7 idle stop");
      step(0, 1, 0, 0, "R2 start");

      // R9: run to full scale and beyond
      for (int i = 0; i < MAXV; i++) step(0, 0, 0, 1, "R3 tick");
      step(0, 0, 0, 0, "R5 follow");
      chk("R9 at full scale", digits, 8'h99);
      chk("R9 still running", W'(running), W'(1));
      step(0, 0, 0, 1, "R9 overflow tick");
      chk("R9 overflow raised", W'(overflow), W'(1));
      chk("R9 run dropped", W'(running), W'(0));
      repeat (3) step(0, 1, 1, 1, "R9 sticky");
      chk("R9 saturated", digits, 8'h99);
      step(1, 0, 0, 0, "R1 clear after overflow");
      chk("R1 overflow cleared", W'(overflow), W'(0));

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         bit c = ($urandom % 100) < 1;
         bit s = ($urandom % 100) < 3;
         bit p = ($urandom % 100) < 2;
         bit t = ($urandom % 100) < 40;
         step(c, s, p, t, "R5 random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule